// File: doc/BRIEF.md
# PHY Discovery and Autonegotiation Sequencer

This block is a control sequencer that sits above a management-bus (MDIO) frame master. After a start pulse it searches the 32 management addresses for an attached PHY and checks each candidate's two identifier words. It then resets the first acceptable PHY, reads its vendor status word to learn the link speed and duplex, and programs the PHY's interrupt mask. Next it builds an autonegotiation advertisement from the PHY's ability bits, restarts autonegotiation and polls until it completes. Polling intervals are counted in ticks of a millisecond strobe, so the block needs no knowledge of the system clock frequency.

The block reaches the MDIO master through a simple request/response port. It raises a one-cycle request only while the master reports idle, keeps at most one transaction outstanding, and moves on when the response strobe arrives. At the end of every run a single-cycle done pulse appears, and the found, failed, address, speed and duplex outputs are already valid in that cycle. These outputs hold until the next start.

Top module: `phy_aneg_seq`

## Requirements
- R1: Addresses are tried in ascending order starting at 0. At each address register 2 is read, then register 3. The first address that is accepted becomes `phyAddr` and `phyFound` is set.
- R2: An address is accepted only when neither identifier word is 16'h0000, 16'hFFFF or 16'h8000.
- R3: If none of the 32 addresses is accepted, the run ends with `phyFound`=0 and `cfgFailed`=1, and no write is ever issued.
- R4: After an address is accepted, register 0 is written with 16'h8000. Register 0 is then read up to RESET_TRIES (6) times until bit 15 reads 0. Between reads the block waits POLL_MS (500) ticks. If bit 15 is still 1 on the last read, the run ends failed.
- R5: After reset completes, register 18 is read. Its bit 7 drives `linkSpeed100` and its bit 6 drives `linkFullDuplex`. Both outputs are cleared at start.
- R6: Register 19 is then written with the parameter IRQ_MASK (default 16'h7EC0).
- R7: Register 1 is read and register 4 is written with 16'h0001. Status bits 15, 14, 13, 12 and 11 are copied to advertisement bits 9, 8, 7, 6 and 5.
- R8: Register 0 is then written with 16'h1200, and register 1 is polled up to ANEG_TRIES (20) times, POLL_MS ticks apart, until bit 5 (complete) is 1. If bit 5 is never set, the run ends failed.
- R9: When a poll shows bit 4 (remote fault) without completion, register 0 is written with 16'h3300 after the wait and before the next poll. If the completing read still shows bit 4, the run ends failed.
- R10: A request is raised only while `mdioBusy` is low. No new request is raised before the response to the previous one.
- R11: `seqDone` is high for exactly one cycle per run. `phyFound` and `cfgFailed` are valid in that cycle and hold afterwards.
- R12: After reset, all outputs are low and no request is raised until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a discovery run (accepted when idle) |
| msTick | input | 1 | One-cycle strobe per millisecond |
| mdioBusy | input | 1 | MDIO master is busy |
| mdioReqValid | output | 1 | One-cycle transaction request |
| mdioReqWrite | output | 1 | 1 = write, 0 = read |
| mdioReqPhy | output | ADDR_W | PHY address of the request |
| mdioReqReg | output | 5 | Register number of the request |
| mdioReqData | output | 16 | Write data |
| mdioRspValid | input | 1 | Transaction finished |
| mdioRspData | input | 16 | Read data |
| phyFound | output | 1 | A PHY was accepted |
| phyAddr | output | ADDR_W | Accepted PHY address |
| linkSpeed100 | output | 1 | 1 = 100 Mb/s reported |
| linkFullDuplex | output | 1 | 1 = full duplex reported |
| cfgFailed | output | 1 | Run ended without a usable link configuration |
| seqDone | output | 1 | End-of-run pulse |

## Verification
The PHY model in the bench is driven from a table of scenarios.

- **Address scan (R1, R2):** the PHY is placed at the lowest address, at the highest address and at an address in between. A rejectable identifier pair sits below it, using 0x8000, 0x0000 or 0xFFFF in one word. This separates correct ascending-order rejection from accepting the first reply.
- **Retry limits (R4, R8):** reset is made to clear on the first read, on the sixth read and never. Autonegotiation is made to complete at once, late, or never. This pins each retry limit to the exact boundary.
- **Remote fault (R9):** in one pattern the fault clears before completion, and in another it persists into the completing read. This tells a restart-and-recover run from a failed one.
- **Advertisement and poll spacing (R7):** varied ability words expose any misrouted advertisement bit. The spacing of successive polls confirms the tick-based wait.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ID1, S_RD_ID2, S_WR_RST, S_RD_CTL, S_WAIT_RST, S_RD_VEND,
    S_WR_MASK, S_RD_CAPS, S_WR_ADV, S_WR_ANEG, S_RD_STAT, S_WAIT_ANEG,
    S_WR_RESTART, S_FINISH
  } seqState_e;

  typedef struct packed {
    logic clrAll;
    logic capId1;
    logic incAddr;
    logic setFound;
    logic setFailed;
    logic clrTries;
    logic incTries;
    logic clrWait;
    logic countMs;
    logic capVendor;
    logic capCaps;
    logic capStatus;
  } seqStrobe_t;

  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ID1  = 5'd2;
  localparam logic [4:0] REG_ID2  = 5'd3;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [4:0] REG_VEND = 5'd18;
  localparam logic [4:0] REG_MASK = 5'd19;

  localparam logic [15:0] CTL_RESET      = 16'h8000;
  localparam logic [15:0] CTL_ANEG       = 16'h1200;
  localparam logic [15:0] CTL_ANEG_FORCE = 16'h3300;

  localparam int CTL_RESET_BIT  = 15;
  localparam int STAT_DONE_BIT  = 5;
  localparam int STAT_RF_BIT    = 4;
  localparam int VEND_SPD_BIT   = 7;
  localparam int VEND_DPX_BIT   = 6;
  localparam int CAP_LO_BIT     = 11;
  localparam int ADV_LO_BIT     = 5;
  localparam int ABILITY_COUNT  = 5;

  function automatic logic idWordOk(input logic [15:0] w);
    return (w != 16'h0000) && (w != 16'hFFFF) && (w != 16'h8000);
  endfunction

  function automatic logic [15:0] buildAdv(input logic [15:0] caps);
    logic [15:0] adv;
    adv = 16'h0001;
    for (int i = 0; i < ABILITY_COUNT; i++) adv[ADV_LO_BIT+i] = caps[CAP_LO_BIT+i];
    return adv;
  endfunction

endpackage

// File: rtl/physeq_datapath.sv
module physeq_datapath
  import physeq_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int POLL_MS     = 500,
  parameter int RESET_TRIES = 6,
  parameter int ANEG_TRIES  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  seqStrobe_t        stb,
  input  logic [15:0]       rspData,
  output logic [ADDR_W-1:0] scanAddr,
  output logic [15:0]       advWord,
  output logic              idOk,
  output logic              lastAddr,
  output logic              rstLastTry,
  output logic              anegLastTry,
  output logic              waitDone,
  output logic              rfSeen,
  output logic              found,
  output logic              failed,
  output logic              speed100,
  output logic              fullDuplex
);
  localparam int TRY_MAX = (RESET_TRIES > ANEG_TRIES) ? RESET_TRIES : ANEG_TRIES;
  localparam int TRY_W   = $clog2(TRY_MAX + 1);
  localparam int MS_W    = $clog2(POLL_MS + 1);

  logic [15:0]      id1Q;
  logic [TRY_W-1:0] tries;
  logic [MS_W-1:0]  msCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanAddr   <= '0;
      advWord    <= '0;
      id1Q       <= '0;
      tries      <= '0;
      msCnt      <= '0;
      rfSeen     <= 1'b0;
      found      <= 1'b0;
      failed     <= 1'b0;
      speed100   <= 1'b0;
      fullDuplex <= 1'b0;
    end else begin
      if (stb.clrAll) begin
        scanAddr   <= '0;
        advWord    <= '0;
        rfSeen     <= 1'b0;
        found      <= 1'b0;
        failed     <= 1'b0;
        speed100   <= 1'b0;
        fullDuplex <= 1'b0;
      end
      if (stb.incAddr)   scanAddr <= scanAddr + 1'b1;
      if (stb.capId1)    id1Q <= rspData;
      if (stb.setFound)  found <= 1'b1;
      if (stb.setFailed) failed <= 1'b1;
      if (stb.clrTries)      tries <= '0;
      else if (stb.incTries) tries <= tries + 1'b1;
      if (stb.clrWait)                               msCnt <= '0;
      else if (stb.countMs && msTick && !waitDone)   msCnt <= msCnt + 1'b1;
      if (stb.capVendor) begin
        speed100   <= rspData[VEND_SPD_BIT];
        fullDuplex <= rspData[VEND_DPX_BIT];
      end
      if (stb.capCaps)   advWord <= buildAdv(rspData);
      if (stb.capStatus) rfSeen <= rspData[STAT_RF_BIT];
    end
  end

  assign idOk        = idWordOk(id1Q) && idWordOk(rspData);
  assign lastAddr    = &scanAddr;
  assign rstLastTry  = (tries == TRY_W'(RESET_TRIES - 1));
  assign anegLastTry = (tries == TRY_W'(ANEG_TRIES - 1));
  assign waitDone    = (msCnt == MS_W'(POLL_MS));

endmodule

// File: rtl/physeq_ctrl.sv
module physeq_ctrl
  import physeq_pkg::*;
#(
  parameter logic [15:0] IRQ_MASK = 16'h7EC0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        mdioBusy,
  input  logic        rspValid,
  input  logic [15:0] rspData,
  input  logic [15:0] advWord,
  input  logic        idOk,
  input  logic        lastAddr,
  input  logic        rstLastTry,
  input  logic        anegLastTry,
  input  logic        waitDone,
  input  logic        rfSeen,
  output logic        reqValid,
  output logic        reqWrite,
  output logic [4:0]  reqReg,
  output logic [15:0] reqData,
  output logic        done,
  output seqStrobe_t  stb
);
  seqState_e state, nextState;
  logic pending, isOp, got;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pending <= 1'b0;
    end else begin
      state <= nextState;
      if (reqValid) pending <= 1'b1;
      else if (got) pending <= 1'b0;
    end
  end

  always_comb begin
    isOp     = 1'b1;
    reqWrite = 1'b0;
    reqReg   = REG_ID1;
    reqData  = '0;
    case (state)
      S_RD_ID1:     reqReg = REG_ID1;
      S_RD_ID2:     reqReg = REG_ID2;
      S_WR_RST:     begin reqWrite = 1'b1; reqReg = REG_CTRL; reqData = CTL_RESET; end
      S_RD_CTL:     reqReg = REG_CTRL;
      S_RD_VEND:    reqReg = REG_VEND;
      S_WR_MASK:    begin reqWrite = 1'b1; reqReg = REG_MASK; reqData = IRQ_MASK; end
      S_RD_CAPS:    reqReg = REG_STAT;
      S_WR_ADV:     begin reqWrite = 1'b1; reqReg = REG_ADV; reqData = advWord; end
      S_WR_ANEG:    begin reqWrite = 1'b1; reqReg = REG_CTRL; reqData = CTL_ANEG; end
      S_RD_STAT:    reqReg = REG_STAT;
      S_WR_RESTART: begin reqWrite = 1'b1; reqReg = REG_CTRL; reqData = CTL_ANEG_FORCE; end
      default:      isOp = 1'b0;
    endcase
  end

  assign reqValid = isOp && !pending && !mdioBusy;
  assign got      = pending && rspValid;
  assign done     = (state == S_FINISH);

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (start) begin stb.clrAll = 1'b1; nextState = S_RD_ID1; end
      S_RD_ID1: if (got) begin stb.capId1 = 1'b1; nextState = S_RD_ID2; end
      S_RD_ID2: if (got) begin
        if (idOk)          begin stb.setFound = 1'b1; nextState = S_WR_RST; end
        else if (lastAddr) begin stb.setFailed = 1'b1; nextState = S_FINISH; end
        else               begin stb.incAddr = 1'b1; nextState = S_RD_ID1; end
      end
      S_WR_RST: if (got) begin stb.clrTries = 1'b1; nextState = S_RD_CTL; end
      S_RD_CTL: if (got) begin
        stb.incTries = 1'b1;
        if (!rspData[CTL_RESET_BIT]) nextState = S_RD_VEND;
        else if (rstLastTry)         begin stb.setFailed = 1'b1; nextState = S_FINISH; end
        else                         begin stb.clrWait = 1'b1; nextState = S_WAIT_RST; end
      end
      S_WAIT_RST: begin
        stb.countMs = 1'b1;
        if (waitDone) nextState = S_RD_CTL;
      end
      S_RD_VEND: if (got) begin stb.capVendor = 1'b1; nextState = S_WR_MASK; end
      S_WR_MASK: if (got) nextState = S_RD_CAPS;
      S_RD_CAPS: if (got) begin stb.capCaps = 1'b1; nextState = S_WR_ADV; end
      S_WR_ADV:  if (got) nextState = S_WR_ANEG;
      S_WR_ANEG: if (got) begin stb.clrTries = 1'b1; nextState = S_RD_STAT; end
      S_RD_STAT: if (got) begin
        stb.incTries  = 1'b1;
        stb.capStatus = 1'b1;
        if (rspData[STAT_DONE_BIT]) begin
          stb.setFailed = rspData[STAT_RF_BIT];
          nextState     = S_FINISH;
        end else if (anegLastTry) begin
          stb.setFailed = 1'b1;
          nextState     = S_FINISH;
        end else begin
          stb.clrWait = 1'b1;
          nextState   = S_WAIT_ANEG;
        end
      end
      S_WAIT_ANEG: begin
        stb.countMs = 1'b1;
        if (waitDone) nextState = rfSeen ? S_WR_RESTART : S_RD_STAT;
      end
      S_WR_RESTART: if (got) nextState = S_RD_STAT;
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/phy_aneg_seq.sv
module phy_aneg_seq
  import physeq_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter int          POLL_MS     = 500,
  parameter int          RESET_TRIES = 6,
  parameter int          ANEG_TRIES  = 20,
  parameter logic [15:0] IRQ_MASK    = 16'h7EC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              msTick,
  input  logic              mdioBusy,
  output logic              mdioReqValid,
  output logic              mdioReqWrite,
  output logic [ADDR_W-1:0] mdioReqPhy,
  output logic [4:0]        mdioReqReg,
  output logic [15:0]       mdioReqData,
  input  logic              mdioRspValid,
  input  logic [15:0]       mdioRspData,
  output logic              phyFound,
  output logic [ADDR_W-1:0] phyAddr,
  output logic              linkSpeed100,
  output logic              linkFullDuplex,
  output logic              cfgFailed,
  output logic              seqDone
);
  seqStrobe_t        stb;
  logic [ADDR_W-1:0] scanAddr;
  logic [15:0]       advWord;
  logic idOk, lastAddr, rstLastTry, anegLastTry, waitDone, rfSeen;

  physeq_ctrl #(.IRQ_MASK(IRQ_MASK)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mdioBusy(mdioBusy),
    .rspValid(mdioRspValid), .rspData(mdioRspData), .advWord(advWord),
    .idOk(idOk), .lastAddr(lastAddr), .rstLastTry(rstLastTry),
    .anegLastTry(anegLastTry), .waitDone(waitDone), .rfSeen(rfSeen),
    .reqValid(mdioReqValid), .reqWrite(mdioReqWrite), .reqReg(mdioReqReg),
    .reqData(mdioReqData), .done(seqDone), .stb(stb)
  );

  physeq_datapath #(
    .ADDR_W(ADDR_W), .POLL_MS(POLL_MS),
    .RESET_TRIES(RESET_TRIES), .ANEG_TRIES(ANEG_TRIES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .stb(stb), .rspData(mdioRspData),
    .scanAddr(scanAddr), .advWord(advWord), .idOk(idOk), .lastAddr(lastAddr),
    .rstLastTry(rstLastTry), .anegLastTry(anegLastTry), .waitDone(waitDone),
    .rfSeen(rfSeen), .found(phyFound), .failed(cfgFailed),
    .speed100(linkSpeed100), .fullDuplex(linkFullDuplex)
  );

  assign mdioReqPhy = scanAddr;
  assign phyAddr    = scanAddr;

endmodule

// File: rtl/phy_aneg_seq_chk.sv
module phy_aneg_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       mdioBusy,
  input logic       mdioReqValid,
  input logic       mdioReqWrite,
  input logic [4:0] mdioReqReg,
  input logic       mdioRspValid,
  input logic       phyFound,
  input logic       cfgFailed,
  input logic       seqDone
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rstN)             outstanding <= 1'b0;
    else if (mdioReqValid) outstanding <= 1'b1;
    else if (mdioRspValid) outstanding <= 1'b0;
  end

  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    mdioReqValid |-> !mdioBusy); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    mdioReqValid |-> !outstanding); // R10
  AST_SCAN_READS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (mdioReqValid && !phyFound) |-> (!mdioReqWrite && (mdioReqReg == 5'd2 || mdioReqReg == 5'd3))); // R3
  AST_NOTFOUND_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && !phyFound) |-> cfgFailed); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone); // R11

endmodule

bind phy_aneg_seq phy_aneg_seq_chk i_chk (
  .clk(clk), .rstN(rstN), .mdioBusy(mdioBusy), .mdioReqValid(mdioReqValid),
  .mdioReqWrite(mdioReqWrite), .mdioReqReg(mdioReqReg), .mdioRspValid(mdioRspValid),
  .phyFound(phyFound), .cfgFailed(cfgFailed), .seqDone(seqDone)
);

// File: tb/test_phy_aneg_seq.sv
module test_phy_aneg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  typedef struct packed {
    logic [5:0]  phyAt;
    logic [4:0]  badAddr;
    logic [15:0] badId1;
    logic [15:0] badId2;
    logic [15:0] caps;
    logic [15:0] vend;
    logic [7:0]  rstReads;
    logic [7:0]  anegReads;
    logic [7:0]  rfReads;
    logic        expFound;
    logic [4:0]  expAddr;
    logic        expFailed;
    logic        expSpeed;
    logic        expDuplex;
    logic [15:0] expAdv;
    logic [7:0]  expRestarts;
    logic [7:0]  expCtlReads;
    logic [7:0]  expStatReads;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{6'd5,  5'd2,  16'h8000, 16'h1234, 16'h7800, 16'h00C0, 8'd1, 8'd2,  8'd0,  1'b1, 5'd5,  1'b0, 1'b1, 1'b1, 16'h01E1, 8'd0, 8'd2, 8'd3},
    '{6'd0,  5'd31, 16'h0000, 16'h0000, 16'h8800, 16'h0080, 8'd0, 8'd0,  8'd0,  1'b1, 5'd0,  1'b0, 1'b1, 1'b0, 16'h0221, 8'd0, 8'd1, 8'd1},
    '{6'd31, 5'd30, 16'h0000, 16'h1234, 16'h1000, 16'h0040, 8'd0, 8'd3,  8'd2,  1'b1, 5'd31, 1'b0, 1'b0, 1'b1, 16'h0041, 8'd2, 8'd1, 8'd4},
    '{6'd32, 5'd0,  16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 8'd0, 8'd0,  8'd0,  1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 16'h0000, 8'd0, 8'd0, 8'd0},
    '{6'd7,  5'd31, 16'h0000, 16'h0000, 16'h7800, 16'h00C0, 8'd6, 8'd0,  8'd0,  1'b1, 5'd7,  1'b1, 1'b0, 1'b0, 16'h0000, 8'd0, 8'd6, 8'd0},
    '{6'd7,  5'd31, 16'h0000, 16'h0000, 16'h0800, 16'h0000, 8'd5, 8'd0,  8'd0,  1'b1, 5'd7,  1'b0, 1'b0, 1'b0, 16'h0021, 8'd0, 8'd6, 8'd1},
    '{6'd4,  5'd31, 16'h0000, 16'h0000, 16'h4000, 16'h0080, 8'd0, 8'd20, 8'd0,  1'b1, 5'd4,  1'b1, 1'b1, 1'b0, 16'h0101, 8'd0, 8'd1, 8'd20},
    '{6'd9,  5'd31, 16'h0000, 16'h0000, 16'h2000, 16'h0040, 8'd0, 8'd1,  8'd99, 1'b1, 5'd9,  1'b1, 1'b0, 1'b1, 16'h0081, 8'd1, 8'd1, 8'd2},
    '{6'd3,  5'd1,  16'h0016, 16'hFFFF, 16'h6000, 16'h00C0, 8'd0, 8'd0,  8'd0,  1'b1, 5'd3,  1'b0, 1'b1, 1'b1, 16'h0181, 8'd0, 8'd1, 8'd1}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, msTick = 1'b0;
  logic mdioBusy = 1'b0, mdioRspValid = 1'b0;
  logic [15:0] mdioRspData = '0;
  logic mdioReqValid, mdioReqWrite;
  logic [4:0] mdioReqPhy, mdioReqReg, phyAddr;
  logic [15:0] mdioReqData;
  logic phyFound, linkSpeed100, linkFullDuplex, cfgFailed, seqDone;

  int nChecks = 0, nFail = 0;
  vec_t cur;
  int cnt = 0, cyc = 0, reqCount = 0, protoErr = 0;
  int ctlReads, statReads, restarts, rstWrites, scanIdx, orderErr;
  int prevCtlCyc, prevStatCyc, ctlGap, statGap;
  logic anegStarted;
  logic [15:0] advSeen, maskSeen, rd;

  phy_aneg_seq i_phy_aneg_seq (
    .clk(clk), .rstN(rstN), .start(start), .msTick(msTick), .mdioBusy(mdioBusy),
    .mdioReqValid(mdioReqValid), .mdioReqWrite(mdioReqWrite), .mdioReqPhy(mdioReqPhy),
    .mdioReqReg(mdioReqReg), .mdioReqData(mdioReqData), .mdioRspValid(mdioRspValid),
    .mdioRspData(mdioRspData), .phyFound(phyFound), .phyAddr(phyAddr),
    .linkSpeed100(linkSpeed100), .linkFullDuplex(linkFullDuplex),
    .cfgFailed(cfgFailed), .seqDone(seqDone)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) msTick <= ~msTick;

  task automatic clearModel();
    ctlReads = 0; statReads = 0; restarts = 0; rstWrites = 0; scanIdx = 0; orderErr = 0;
    prevCtlCyc = 0; prevStatCyc = 0; ctlGap = 0; statGap = 0;
    anegStarted = 1'b0; advSeen = '0; maskSeen = '0;
  endtask

  // PHY model behind a three-cycle MDIO master
  always @(posedge clk) begin
    cyc++;
    mdioRspValid <= 1'b0;
    if (mdioReqValid && mdioBusy) protoErr++;
    if (!rstN) begin
      mdioBusy <= 1'b0;
      cnt = 0;
    end else if (cnt != 0) begin
      cnt--;
      if (cnt == 0) begin mdioRspValid <= 1'b1; mdioBusy <= 1'b0; end
    end else if (mdioReqValid) begin
      reqCount++;
      mdioBusy <= 1'b1;
      cnt = 3;
      rd = 16'hFFFF;
      if (!mdioReqWrite) begin
        if (mdioReqReg == 5'd2 || mdioReqReg == 5'd3) begin
          if (mdioReqPhy != 5'(scanIdx >> 1) || mdioReqReg != 5'(2 + (scanIdx & 1))) orderErr++;
          scanIdx++;
        end
        if (cur.phyAt[5] || mdioReqPhy != cur.phyAt[4:0]) begin
          if (mdioReqPhy == cur.badAddr && mdioReqReg == 5'd2) rd = cur.badId1;
          else if (mdioReqPhy == cur.badAddr && mdioReqReg == 5'd3) rd = cur.badId2;
        end else begin
          case (mdioReqReg)
            5'd2: rd = 16'h0016;
            5'd3: rd = 16'hF841;
            5'd0: begin
              ctlReads++;
              if (ctlReads > 1) ctlGap = cyc - prevCtlCyc;
              prevCtlCyc = cyc;
              rd = (ctlReads <= int'(cur.rstReads)) ? 16'h8000 : 16'h0000;
            end
            5'd18: rd = cur.vend;
            5'd1: begin
              rd = cur.caps;
              if (anegStarted) begin
                statReads++;
                if (statReads > 1) statGap = cyc - prevStatCyc;
                prevStatCyc = cyc;
                if (statReads > int'(cur.anegReads)) rd[5] = 1'b1;
                if (statReads <= int'(cur.rfReads)) rd[4] = 1'b1;
              end
            end
            default: rd = 16'h0000;
          endcase
        end
        mdioRspData <= rd;
      end else begin
        case (mdioReqReg)
          5'd0: begin
            if (mdioReqData == 16'h8000) rstWrites++;
            if (mdioReqData == 16'h1200) anegStarted = 1'b1;
            if (mdioReqData == 16'h3300) restarts++;
          end
          5'd4:  advSeen = mdioReqData;
          5'd19: maskSeen = mdioReqData;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    cur = VECS[0];
    clearModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state and no activity before start
    chk("R12", "done after reset", 32'(seqDone), 0);
    chk("R12", "found after reset", 32'(phyFound), 0);
    chk("R12", "failed after reset", 32'(cfgFailed), 0);
    chk("R12", "speed after reset", 32'(linkSpeed100), 0);
    repeat (10) @(negedge clk);
    chk("R12", "requests before start", 32'(reqCount), 0);

    for (int v = 0; v < NVEC; v++) begin
      cur = VECS[v];
      clearModel();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!seqDone) @(negedge clk);
      chk("R1", "found", 32'(phyFound), 32'(cur.expFound));
      if (cur.expFound) chk("R1", "address", 32'(phyAddr), 32'(cur.expAddr));
      chk("R1", "scan order errors", 32'(orderErr), 0);
      chk("R2", "id reads", 32'(scanIdx), cur.expFound ? 32'(2 * (cur.expAddr + 1)) : 32'd64);
      chk("R11", "failed at done", 32'(cfgFailed), 32'(cur.expFailed));
      chk("R5", "speed", 32'(linkSpeed100), 32'(cur.expSpeed));
      chk("R5", "duplex", 32'(linkFullDuplex), 32'(cur.expDuplex));
      chk("R3", "reset writes", 32'(rstWrites), 32'(cur.expFound));
      chk("R4", "control reads", 32'(ctlReads), 32'(cur.expCtlReads));
      chk("R7", "advertisement", 32'(advSeen), 32'(cur.expAdv));
      chk("R6", "irq mask", 32'(maskSeen), (cur.expAdv != 0) ? 32'h7EC0 : 32'h0);
      chk("R8", "status polls", 32'(statReads), 32'(cur.expStatReads));
      chk("R9", "forced restarts", 32'(restarts), 32'(cur.expRestarts));
      if (v == 0) begin
        chk("R4", "reset poll spacing ok", 32'(ctlGap >= 1000 && ctlGap <= 1020), 1);
        chk("R8", "aneg poll spacing ok", 32'(statGap >= 1000 && statGap <= 1020), 1);
      end
      @(negedge clk);
      chk("R11", "done one cycle", 32'(seqDone), 0);
      chk("R11", "found held", 32'(phyFound), 32'(cur.expFound));
      repeat (3) @(negedge clk);
    end

    chk("R10", "requests while busy", 32'(protoErr), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule